// File: doc/BRIEF.md
# EEPROM Byte Access and Burst Loader

This block lets a host reach an external byte-wide EEPROM through a small register file. Three kinds of request are supported: fetch one byte, store one byte, and a burst read that walks a stream of records in the EEPROM and copies their payload into device memory. The host writes an EEPROM address and, for stores, a data byte, then sets a request bit. The bit clears itself when the transfer is complete, so the host polls it.

A burst reads records laid out as a 16-bit destination address (high byte first), a byte count, then that many payload bytes. Each payload byte becomes one write on the memory port. The destination address is built from a 9-bit base register on top and the low 15 bits of the record address. A record whose count is zero ends the burst. The first burst after reset starts at EEPROM address 0. Any later burst starts one past the last EEPROM address touched, whether by a single access or by a burst.

The EEPROM side is a plain request/acknowledge byte port. Only one request runs at a time. A request that arrives while the block is busy is dropped and raises a sticky error flag.

Top module: `nvm_loader`

## Requirements
- R1: Writing the control register (select 0) with bit 1 set fetches the byte at the address register (select 1) into the data register (select 2). Control bit 1 reads 1 until the fetch completes and 0 afterwards, and the data register then holds the fetched byte.
- R2: Writing control with bit 0 set (bit 1 clear) stores the data register byte at the address register location. Control bit 0 reads 1 until the store completes, then 0.
- R3: A control write with both bit 0 and bit 1 set performs only the fetch. The EEPROM location is not written.
- R4: Writing the burst register (select 3) with bit 0 set starts a burst. That bit reads 1 while the burst runs and returns to 0 when it ends.
- R5: The first burst after reset starts at EEPROM address 0. Every later burst starts at (last accessed EEPROM address + 1) modulo 2^EE_AW. Every single access and every byte fetched by a burst, including the terminating count, updates the last accessed address.
- R6: A burst record is: destination high byte, destination low byte, count, then count payload bytes. Each payload byte produces exactly one memory write, in stream order. A count of 0 ends the burst.
- R7: The memory write address is {base register (select 4) bits [8:0], record address bits [14:0]}. Bit 15 of the record address is ignored. The low 15 bits advance by one per payload byte and wrap within 15 bits without touching the base part.
- R8: While any request is pending, a control or burst write that sets a request bit is ignored and sets control bit 2. Bit 2 stays set until reset. Writes to the address, data and base registers are also ignored while busy.
- R9: On the EEPROM port, once ee_req is raised, it and ee_addr, ee_we and ee_wdata stay stable until the cycle ee_ack is high. Each such cycle completes one transfer.
- R10: After reset all registers read 0, ee_req is low and no memory write occurs.
- R11: reg_rdata is registered and shows the register that reg_sel selected in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select: 0 control, 1 address, 2 data, 3 burst, 4 base |
| reg_wdata | input | REG_DW | Register write data |
| reg_rdata | output | REG_DW | Registered read data |
| ee_req | output | 1 | EEPROM transfer request |
| ee_we | output | 1 | EEPROM transfer is a store |
| ee_addr | output | EE_AW | EEPROM byte address |
| ee_wdata | output | 8 | EEPROM store byte |
| ee_ack | input | 1 | EEPROM transfer complete |
| ee_rdata | input | 8 | EEPROM fetched byte, valid with ee_ack |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | MEM_AW | Memory write address |
| mem_wdata | output | 8 | Memory write byte |

## Verification
The assertions assume that the EEPROM model raises ee_ack only while ee_req is high, for a single cycle per transfer, and that every burst stream ends with a zero count. The bench models the EEPROM with a random 0 to 3 cycle acknowledge delay. Its model drops ack after every acknowledged cycle, and it places a terminating record after each set of records it writes at the predicted start address. Host register writes are applied one at a time at the falling edge.

// File: rtl/nvm_loader_pkg.sv
package nvm_loader_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_SINGLE,
    SQ_HDR_HI,
    SQ_HDR_LO,
    SQ_COUNT,
    SQ_DATA
  } seq_state_e;

  localparam logic [2:0] SEL_CTRL  = 3'd0;
  localparam logic [2:0] SEL_ADDR  = 3'd1;
  localparam logic [2:0] SEL_DATA  = 3'd2;
  localparam logic [2:0] SEL_BURST = 3'd3;
  localparam logic [2:0] SEL_BASE  = 3'd4;

  localparam int CTL_WR_BIT  = 0;
  localparam int CTL_RD_BIT  = 1;
  localparam int CTL_ERR_BIT = 2;

endpackage

// File: rtl/nvm_regs.sv
module nvm_regs
  import nvm_loader_pkg::*;
#(
  parameter int EE_AW  = 16,
  parameter int BASE_W = 9,
  parameter int REG_DW = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [2:0]        reg_sel,
  input  logic [REG_DW-1:0] reg_wdata,
  output logic [REG_DW-1:0] reg_rdata,
  input  logic              sgl_done,
  input  logic [7:0]        sgl_rbyte,
  input  logic              burst_done,
  output logic              go_rd,
  output logic              go_wr,
  output logic              go_burst,
  output logic [EE_AW-1:0]  addr_q,
  output logic [7:0]        data_q,
  output logic [BASE_W-1:0] base_q,
  output logic              rd_q,
  output logic              wr_q,
  output logic              burst_q,
  output logic              err_q,
  output logic              busy
);

  logic ctl_hit, req_rd, req_wr, req_b, any_req;

  assign busy    = rd_q | wr_q | burst_q;
  assign ctl_hit = reg_wr && (reg_sel == SEL_CTRL);
  assign req_rd  = ctl_hit && reg_wdata[CTL_RD_BIT];
  assign req_wr  = ctl_hit && reg_wdata[CTL_WR_BIT];
  assign req_b   = reg_wr && (reg_sel == SEL_BURST) && reg_wdata[0];
  assign any_req = req_rd | req_wr | req_b;

  assign go_rd    = !busy && req_rd;
  assign go_wr    = !busy && req_wr && !req_rd;
  assign go_burst = !busy && req_b;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q    <= 1'b0;
      wr_q    <= 1'b0;
      burst_q <= 1'b0;
      err_q   <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
      base_q  <= '0;
    end else begin
      if (busy && any_req) err_q <= 1'b1;

      if (go_rd)         rd_q <= 1'b1;
      else if (sgl_done) rd_q <= 1'b0;

      if (go_wr)         wr_q <= 1'b1;
      else if (sgl_done) wr_q <= 1'b0;

      if (go_burst)        burst_q <= 1'b1;
      else if (burst_done) burst_q <= 1'b0;

      if (!busy && reg_wr) begin
        case (reg_sel)
          SEL_ADDR: addr_q <= reg_wdata[EE_AW-1:0];
          SEL_DATA: data_q <= reg_wdata[7:0];
          SEL_BASE: base_q <= reg_wdata[BASE_W-1:0];
          default: ;
        endcase
      end

      if (sgl_done && rd_q) data_q <= sgl_rbyte;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      case (reg_sel)
        SEL_CTRL:  reg_rdata <= REG_DW'({err_q, rd_q, wr_q});
        SEL_ADDR:  reg_rdata <= REG_DW'(addr_q);
        SEL_DATA:  reg_rdata <= REG_DW'(data_q);
        SEL_BURST: reg_rdata <= REG_DW'(burst_q);
        SEL_BASE:  reg_rdata <= REG_DW'(base_q);
        default:   reg_rdata <= '0;
      endcase
    end
  end

endmodule

// File: rtl/nvm_addr_track.sv
module nvm_addr_track #(
  parameter int EE_AW = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fire,
  input  logic [EE_AW-1:0] fire_addr,
  output logic [EE_AW-1:0] resume_addr
);

  logic             fresh_q;
  logic [EE_AW-1:0] last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      fresh_q <= 1'b1;
      last_q  <= '0;
    end else if (fire) begin
      fresh_q <= 1'b0;
      last_q  <= fire_addr;
    end
  end

  assign resume_addr = fresh_q ? '0 : last_q + EE_AW'(1);

endmodule

// File: rtl/nvm_seq.sv
module nvm_seq
  import nvm_loader_pkg::*;
#(
  parameter int EE_AW  = 16,
  parameter int MEM_AW = 24,
  parameter int LOW_W  = 15,
  localparam int BASE_W = MEM_AW - LOW_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go_rd,
  input  logic              go_wr,
  input  logic              go_burst,
  input  logic [EE_AW-1:0]  addr_q,
  input  logic [7:0]        data_q,
  input  logic [BASE_W-1:0] base_q,
  input  logic [EE_AW-1:0]  resume_addr,
  output logic              ee_req,
  output logic              ee_we,
  output logic [EE_AW-1:0]  ee_addr,
  output logic [7:0]        ee_wdata,
  input  logic              ee_ack,
  input  logic [7:0]        ee_rdata,
  output logic              mem_we,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic              fire,
  output logic              sgl_done,
  output logic              burst_done,
  output logic              seq_idle
);

  seq_state_e       state_q;
  logic [7:0]       hdr_hi_q;
  logic [LOW_W-1:0] dest_q;
  logic [7:0]       cnt_q;

  assign fire       = ee_req && ee_ack;
  assign sgl_done   = fire && (state_q == SQ_SINGLE);
  assign burst_done = fire && (state_q == SQ_COUNT) && (ee_rdata == 8'd0);
  assign seq_idle   = (state_q == SQ_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= SQ_IDLE;
      ee_req    <= 1'b0;
      ee_we     <= 1'b0;
      ee_addr   <= '0;
      ee_wdata  <= '0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      hdr_hi_q  <= '0;
      dest_q    <= '0;
      cnt_q     <= '0;
    end else begin
      mem_we <= 1'b0;
      case (state_q)
        SQ_IDLE: begin
          if (go_rd || go_wr) begin
            ee_req   <= 1'b1;
            ee_we    <= go_wr;
            ee_addr  <= addr_q;
            ee_wdata <= data_q;
            state_q  <= SQ_SINGLE;
          end else if (go_burst) begin
            ee_req  <= 1'b1;
            ee_we   <= 1'b0;
            ee_addr <= resume_addr;
            state_q <= SQ_HDR_HI;
          end
        end
        SQ_SINGLE: begin
          if (fire) begin
            ee_req  <= 1'b0;
            ee_we   <= 1'b0;
            state_q <= SQ_IDLE;
          end
        end
        SQ_HDR_HI: begin
          if (fire) begin
            hdr_hi_q <= ee_rdata;
            ee_addr  <= ee_addr + EE_AW'(1);
            state_q  <= SQ_HDR_LO;
          end
        end
        SQ_HDR_LO: begin
          if (fire) begin
            dest_q  <= LOW_W'({hdr_hi_q, ee_rdata});
            ee_addr <= ee_addr + EE_AW'(1);
            state_q <= SQ_COUNT;
          end
        end
        SQ_COUNT: begin
          if (fire) begin
            if (ee_rdata == 8'd0) begin
              ee_req  <= 1'b0;
              state_q <= SQ_IDLE;
            end else begin
              cnt_q   <= ee_rdata;
              ee_addr <= ee_addr + EE_AW'(1);
              state_q <= SQ_DATA;
            end
          end
        end
        SQ_DATA: begin
          if (fire) begin
            mem_we    <= 1'b1;
            mem_addr  <= {base_q, dest_q};
            mem_wdata <= ee_rdata;
            dest_q    <= dest_q + LOW_W'(1);
            cnt_q     <= cnt_q - 8'd1;
            ee_addr   <= ee_addr + EE_AW'(1);
            if (cnt_q == 8'd1) state_q <= SQ_HDR_HI;
          end
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/nvm_loader.sv
module nvm_loader #(
  parameter int EE_AW  = 16,
  parameter int MEM_AW = 24,
  parameter int LOW_W  = 15,
  parameter int REG_DW = 16,
  localparam int BASE_W = MEM_AW - LOW_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [2:0]        reg_sel,
  input  logic [REG_DW-1:0] reg_wdata,
  output logic [REG_DW-1:0] reg_rdata,
  output logic              ee_req,
  output logic              ee_we,
  output logic [EE_AW-1:0]  ee_addr,
  output logic [7:0]        ee_wdata,
  input  logic              ee_ack,
  input  logic [7:0]        ee_rdata,
  output logic              mem_we,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [7:0]        mem_wdata
);

  logic              go_rd_w, go_wr_w, go_burst_w;
  logic [EE_AW-1:0]  host_addr_w, resume_w;
  logic [7:0]        host_data_w;
  logic [BASE_W-1:0] base_w;
  logic              rd_pend_w, wr_pend_w, burst_pend_w, err_w, busy_w;
  logic              fire_w, sgl_done_w, burst_done_w, seq_idle_w;

  nvm_regs #(
    .EE_AW (EE_AW),
    .BASE_W(BASE_W),
    .REG_DW(REG_DW)
  ) u_regs (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .sgl_done  (sgl_done_w),
    .sgl_rbyte (ee_rdata),
    .burst_done(burst_done_w),
    .go_rd     (go_rd_w),
    .go_wr     (go_wr_w),
    .go_burst  (go_burst_w),
    .addr_q    (host_addr_w),
    .data_q    (host_data_w),
    .base_q    (base_w),
    .rd_q      (rd_pend_w),
    .wr_q      (wr_pend_w),
    .burst_q   (burst_pend_w),
    .err_q     (err_w),
    .busy      (busy_w)
  );

  nvm_addr_track #(
    .EE_AW(EE_AW)
  ) u_track (
    .clk        (clk),
    .rst        (rst),
    .fire       (fire_w),
    .fire_addr  (ee_addr),
    .resume_addr(resume_w)
  );

  nvm_seq #(
    .EE_AW (EE_AW),
    .MEM_AW(MEM_AW),
    .LOW_W (LOW_W)
  ) u_seq (
    .clk        (clk),
    .rst        (rst),
    .go_rd      (go_rd_w),
    .go_wr      (go_wr_w),
    .go_burst   (go_burst_w),
    .addr_q     (host_addr_w),
    .data_q     (host_data_w),
    .base_q     (base_w),
    .resume_addr(resume_w),
    .ee_req     (ee_req),
    .ee_we      (ee_we),
    .ee_addr    (ee_addr),
    .ee_wdata   (ee_wdata),
    .ee_ack     (ee_ack),
    .ee_rdata   (ee_rdata),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .fire       (fire_w),
    .sgl_done   (sgl_done_w),
    .burst_done (burst_done_w),
    .seq_idle   (seq_idle_w)
  );

endmodule

// File: rtl/nvm_loader_chk.sv
module nvm_loader_chk #(
  parameter int EE_AW  = 16,
  parameter int MEM_AW = 24,
  parameter int LOW_W  = 15,
  localparam int BASE_W = MEM_AW - LOW_W
) (
  input logic              clk,
  input logic              rst,
  input logic              ee_req,
  input logic              ee_ack,
  input logic              ee_we,
  input logic [EE_AW-1:0]  ee_addr,
  input logic [7:0]        ee_wdata,
  input logic              mem_we,
  input logic [MEM_AW-1:0] mem_addr,
  input logic [BASE_W-1:0] base_q,
  input logic              rd_q,
  input logic              wr_q,
  input logic              burst_q,
  input logic              err_q,
  input logic              busy,
  input logic              seq_idle
);

  assert_hold_req_R9: assert property (@(posedge clk) disable iff (rst)
    (ee_req && !ee_ack) |=> (ee_req && $stable(ee_addr) && $stable(ee_we) && $stable(ee_wdata)));

  assert_one_kind_R3: assert property (@(posedge clk) disable iff (rst)
    !(rd_q && wr_q));

  assert_mem_base_R7: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (mem_addr[MEM_AW-1:LOW_W] == base_q));

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    err_q |=> err_q);

  assert_state_match_R4: assert property (@(posedge clk) disable iff (rst)
    busy == !seq_idle);

  assert_mem_in_burst_R6: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> burst_q);

  assert_quiet_idle_R10: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !ee_req);

endmodule

bind nvm_loader nvm_loader_chk #(
  .EE_AW (EE_AW),
  .MEM_AW(MEM_AW),
  .LOW_W (LOW_W)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .ee_req  (ee_req),
  .ee_ack  (ee_ack),
  .ee_we   (ee_we),
  .ee_addr (ee_addr),
  .ee_wdata(ee_wdata),
  .mem_we  (mem_we),
  .mem_addr(mem_addr),
  .base_q  (base_w),
  .rd_q    (rd_pend_w),
  .wr_q    (wr_pend_w),
  .burst_q (burst_pend_w),
  .err_q   (err_w),
  .busy    (busy_w),
  .seq_idle(seq_idle_w)
);

// File: tb/sim_nvm_loader.sv
module sim_nvm_loader;

  localparam int CLK_PERIOD = 10;
  localparam int EE_AW  = 8;
  localparam int EE_SZ  = 1 << EE_AW;
  localparam logic [2:0] S_CTRL = 3'd0, S_ADDR = 3'd1, S_DATA = 3'd2, S_BURST = 3'd3, S_BASE = 3'd4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_sel = 3'd0;
  logic [15:0] reg_wdata = 16'd0;
  logic [15:0] reg_rdata;
  logic        ee_req, ee_we;
  logic [EE_AW-1:0] ee_addr;
  logic [7:0]  ee_wdata;
  logic        ee_ack = 1'b0;
  logic [7:0]  ee_rdata = 8'd0;
  logic        mem_we;
  logic [23:0] mem_addr;
  logic [7:0]  mem_wdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  nvm_loader #(.EE_AW(EE_AW)) u0 (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .ee_req(ee_req), .ee_we(ee_we), .ee_addr(ee_addr),
    .ee_wdata(ee_wdata), .ee_ack(ee_ack), .ee_rdata(ee_rdata), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  logic [7:0] eemem [0:EE_SZ-1];
  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  int last_a = 0;
  bit fresh = 1;

  int n_got = 0;
  logic [23:0] got_a [0:63];
  logic [7:0]  got_d [0:63];
  int n_exp = 0;
  logic [23:0] exp_a [0:63];
  logic [7:0]  exp_d [0:63];

  // EEPROM model: random acknowledge delay, one-cycle ack
  initial begin
    int wcnt;
    wcnt = 0;
    forever begin
      @(posedge clk);
      if (ee_ack) ee_ack <= 1'b0;
      else if (ee_req) begin
        if (wcnt == 0) begin
          ee_ack   <= 1'b1;
          ee_rdata <= eemem[ee_addr];
          if (ee_we) eemem[ee_addr] <= ee_wdata;
          wcnt = $urandom_range(0, 3);
        end else wcnt = wcnt - 1;
      end
    end
  end

  // memory port capture
  initial begin
    forever begin
      @(negedge clk);
      if (mem_we && n_got < 64) begin
        got_a[n_got] = mem_addr;
        got_d[n_got] = mem_wdata;
        n_got = n_got + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk = n_chk + 1;
    if (!ok) begin
      n_fail = n_fail + 1;
      $display("FAIL %s got=%0h exp=%0h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic wr_reg(input logic [2:0] s, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] s, output logic [15:0] v);
    @(negedge clk);
    reg_sel = s;
    @(negedge clk);
    v = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [15:0] c, b;
    for (int i = 0; i < 500; i++) begin
      rd_reg(S_CTRL, c);
      rd_reg(S_BURST, b);
      if (c[1:0] == 2'b00 && b[0] == 1'b0) break;
    end
  endtask

  task automatic put_rec(inout int a, input logic [15:0] dest, input int cnt);
    eemem[a] = dest[15:8]; a = (a + 1) % EE_SZ;
    eemem[a] = dest[7:0];  a = (a + 1) % EE_SZ;
    eemem[a] = cnt[7:0];   a = (a + 1) % EE_SZ;
    for (int i = 0; i < cnt; i++) begin
      eemem[a] = 8'($urandom);
      a = (a + 1) % EE_SZ;
    end
  endtask

  task automatic predict(input int start, input logic [8:0] base, output int term_a);
    int a, cnt;
    logic [14:0] dest;
    a = start; n_exp = 0; term_a = start;
    for (int r = 0; r < 16; r++) begin
      dest[14:8] = eemem[a][6:0]; a = (a + 1) % EE_SZ;
      dest[7:0]  = eemem[a];      a = (a + 1) % EE_SZ;
      cnt = eemem[a];
      if (cnt == 0) begin term_a = a; break; end
      a = (a + 1) % EE_SZ;
      for (int i = 0; i < cnt; i++) begin
        if (n_exp < 64) begin
          exp_a[n_exp] = {base, dest};
          exp_d[n_exp] = eemem[a];
          n_exp = n_exp + 1;
        end
        dest = dest + 15'd1;
        a = (a + 1) % EE_SZ;
      end
    end
  endtask

  function automatic int next_start();
    return fresh ? 0 : (last_a + 1) % EE_SZ;
  endfunction

  task automatic run_burst(input logic [8:0] base, input bit poke_busy);
    int term;
    logic [15:0] v, d0, a0;
    predict(next_start(), base, term);
    wr_reg(S_BASE, {7'd0, base});
    rd_reg(S_DATA, d0);
    rd_reg(S_ADDR, a0);
    n_got = 0;
    wr_reg(S_BURST, 16'd1);
    rd_reg(S_BURST, v);
    chk(v[0] == 1'b1, "R4 burst bit while running", v, 1);
    if (poke_busy) begin
      wr_reg(S_CTRL, 16'h0002);
      wr_reg(S_ADDR, 16'h00AA);
      rd_reg(S_CTRL, v);
      chk(v[2:0] == 3'b100, "R8 busy request rejected, error set", v[2:0], 3'b100);
    end
    wait_idle();
    rd_reg(S_BURST, v);
    chk(v[0] == 1'b0, "R4 burst bit cleared", v, 0);
    chk(n_got == n_exp, "R6 memory write count", n_got, n_exp);
    for (int i = 0; i < n_exp; i++) begin
      chk(got_a[i] == exp_a[i], "R7 memory address", got_a[i], exp_a[i]);
      chk(got_d[i] == exp_d[i], "R6 memory data", got_d[i], exp_d[i]);
    end
    if (poke_busy) begin
      rd_reg(S_DATA, v);
      chk(v == d0, "R8 data register untouched by rejected read", v, d0);
      rd_reg(S_ADDR, v);
      chk(v == a0, "R8 address write ignored while busy", v, a0);
    end
    last_a = term; fresh = 0;
  endtask

  task automatic single_rd(input int a);
    logic [15:0] v;
    wr_reg(S_ADDR, 16'(a));
    wr_reg(S_CTRL, 16'h0002);
    wait_idle();
    rd_reg(S_CTRL, v);
    chk(v[1] == 1'b0, "R1 read bit self-clears", v[1], 0);
    rd_reg(S_DATA, v);
    chk(v[7:0] == eemem[a], "R1 fetched byte", v[7:0], eemem[a]);
    last_a = a; fresh = 0;
  endtask

  task automatic single_wr(input int a, input logic [7:0] d);
    logic [15:0] v;
    wr_reg(S_ADDR, 16'(a));
    wr_reg(S_DATA, {8'd0, d});
    wr_reg(S_CTRL, 16'h0001);
    wait_idle();
    rd_reg(S_CTRL, v);
    chk(v[0] == 1'b0, "R2 write bit self-clears", v[0], 0);
    chk(eemem[a] == d, "R2 stored byte", eemem[a], d);
    last_a = a; fresh = 0;
  endtask

  initial begin
    logic [15:0] v;
    int a;
    void'($urandom(32'h5EED_0017));
    for (int i = 0; i < EE_SZ; i++) eemem[i] = 8'($urandom);
    repeat (5) @(negedge clk);
    rst = 1'b0;

    // reset state
    for (int s = 0; s < 5; s++) begin
      rd_reg(3'(s), v);
      chk(v == 16'd0, "R10 register reset value", v, 0);
    end
    chk(ee_req == 1'b0, "R10 no EEPROM request after reset", ee_req, 0);
    chk(n_got == 0, "R10 no memory write after reset", n_got, 0);

    // registered read data
    wr_reg(S_ADDR, 16'h0033);
    @(negedge clk); reg_sel = S_CTRL;
    @(negedge clk); reg_sel = S_ADDR;
    #1 chk(reg_rdata == 16'd0, "R11 read data lags select", reg_rdata, 0);
    @(negedge clk);
    chk(reg_rdata == 16'h0033, "R11 read data after one edge", reg_rdata, 16'h0033);

    // first burst after reset starts at 0; top record bit ignored
    a = 0;
    put_rec(a, 16'h8010, 3);
    put_rec(a, 16'h0200, 2);
    eemem[a+2] = 8'd0;
    run_burst(9'h1A3, 1'b0);

    // random single accesses
    for (int k = 0; k < 6; k++) begin
      single_rd($urandom_range(0, EE_SZ-1));
      single_wr($urandom_range(0, EE_SZ-1), 8'($urandom));
    end

    // both request bits: fetch only
    a = 77;
    eemem[a] = 8'h5C;
    wr_reg(S_ADDR, 16'(a));
    wr_reg(S_DATA, 16'h00E1);
    wr_reg(S_CTRL, 16'h0003);
    wait_idle();
    rd_reg(S_DATA, v);
    chk(v[7:0] == 8'h5C, "R3 both bits perform fetch", v[7:0], 8'h5C);
    chk(eemem[a] == 8'h5C, "R3 both bits do not store", eemem[a], 8'h5C);
    last_a = a; fresh = 0;

    // burst resumes after single access; 15-bit destination wrap
    a = next_start();
    put_rec(a, 16'h7FFF, 2);
    put_rec(a, 16'h1234, 4);
    eemem[(a+2)%EE_SZ] = 8'd0;
    run_burst(9'h055, 1'b0);

    // burst resumes after terminator; request while busy rejected
    a = next_start();
    put_rec(a, 16'h0400, 12);
    eemem[(a+2)%EE_SZ] = 8'd0;
    run_burst(9'h0F0, 1'b1);

    // address wrap: last access at top address
    single_rd(EE_SZ - 1);
    chk(next_start() == 0, "R5 resume wraps", next_start(), 0);
    a = 0;
    put_rec(a, 16'h0ABC, 5);
    eemem[a+2] = 8'd0;
    run_burst(9'h1FF, 1'b0);

    rd_reg(S_CTRL, v);
    chk(v[2] == 1'b1, "R8 error flag stays set", v[2], 1);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk = n_chk + 1;
      n_fail = n_fail + 1;
      $display("FAIL watchdog R1 got=hung exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

endmodule